// File: doc/BRIEF.md
# AHB Incrementing-Burst Master

This block lets a processor core reach an AHB system bus as a bus master. It serves two request ports: an instruction-fetch port and a data port. It asks the arbiter for the bus and waits for a grant. It then drives the address phase and the control and write-data signals, watches HREADY, and hands the read data back to the core together with a one-cycle completion pulse on the side that asked.

The core gives only one hint about sequential data traffic: a "more" flag. The flag says that at least one further data access follows the current one, but not how many. The block turns a run of such accesses into an undefined-length incrementing burst. It fills the gaps between beats with BUSY and generates each continuation address itself. Fetches carry no such hint, so each fetch is a single NONSEQ read followed by IDLE. A fetch whose address falls below a local-memory boundary, while the local instruction memory is enabled, never reaches the bus.

Each side holds its request and operands stable until its completion pulse. In the cycle of that pulse it may present its next request or withdraw.

Top module: `bmu_ahb_master`

## Requirements
- R1: After reset, HTRANS is IDLE (2'b00), HBUSREQ is low and neither completion pulse is active.
- R2: HBUSREQ rises while an access is pending. A NONSEQ address phase begins only in the cycle after a clock edge at which HGRANT and HREADY were both high.
- R3: While HREADY is low, HTRANS, HADDR and HWRITE keep their values. Completion occurs only at an edge where HREADY is high.
- R4: A data access that follows a data access flagged "more" is issued as SEQ (2'b11) when the grant has been held. Its address is the previous beat's address plus 2^HSIZE, and HBURST is INCR (3'b001). Between the beats only BUSY (2'b01) appears, never IDLE.
- R5: A data access that does not continue a burst is issued as NONSEQ (2'b10) at the core's address. HBURST is SINGLE (3'b000), or INCR when the access itself carries the "more" flag.
- R6: An instruction fetch is a NONSEQ word read (HSIZE 3'b010, HWRITE low, HBURST SINGLE). At least one IDLE cycle comes before the next fetch.
- R7: A fetch is ignored when the local-memory enable is high and the fetch address is below LOCAL_TOP (default 32'h0001_0000). In that case there is no bus request, no transfer and no completion pulse.
- R8: Read data appears on `core_rdata` with the completion pulse, one cycle after the HREADY-high edge that ends the data phase. HWDATA carries the core's write data when a write data phase completes.
- R9: When both ports are pending, the data access goes first. While a burst is open, a pending fetch waits behind the next data beat.
- R10: After an edge where HREADY is high and HGRANT is low, HTRANS is IDLE. An open burst is closed, so the next data access restarts as NONSEQ at the core's address.
- R11: HBUSREQ is low when no access is pending and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_on | input | 1 | Local instruction memory enabled |
| i_req | input | 1 | Fetch request, held until i_done |
| i_addr | input | AW | Fetch address |
| i_done | output | 1 | Fetch completion pulse |
| d_req | input | 1 | Data request, held until d_done |
| d_addr | input | AW | Data address |
| d_write | input | 1 | Data access is a write |
| d_wdata | input | DW | Write data |
| d_size | input | 2 | Transfer size, log2 of bytes |
| d_more | input | 1 | At least one more data access follows |
| d_done | output | 1 | Data completion pulse |
| core_rdata | output | DW | Read data returned to the core |
| hbusreq | output | 1 | Bus request to the arbiter |
| hgrant | input | 1 | Grant from the arbiter |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Address |
| hwrite | output | 1 | Write select |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwdata | output | DW | Write data |
| hready | input | 1 | Transfer done / bus ready |
| hrdata | input | DW | Read data from the slave |

## Verification
Two events can meet in one cycle. First, a fetch and a data access can become pending together, and a fetch can arrive while a burst is open. The bench raises both requests at the same clock, and also holds a fetch during the BUSY gap of a burst. It judges the order of the two completion pulses and checks that no NONSEQ appears for the fetch before the data beat. Second, a grant withdrawal can land on an open burst: the bench's arbiter model revokes the grant in the middle of a burst, both at random and in a directed case. A monitor then requires IDLE after the loss, and the continuation beat must come back as NONSEQ at the core's address.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10
  } phase_t;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;
endpackage

// File: rtl/bmu_addr_step.sv
module bmu_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [2:0]    size,
  output logic [AW-1:0] next
);
  // continuation address of an incrementing burst
  assign next = base + (AW'(1) << size);
endmodule

// File: rtl/bmu_req_select.sv
module bmu_req_select #(
  parameter int              AW        = 32,
  parameter int              DW        = 32,
  parameter logic [AW-1:0]   LOCAL_TOP = 'h0001_0000
) (
  input  logic          imem_on,
  input  logic          i_req,
  input  logic [AW-1:0] i_addr,
  input  logic          d_req,
  input  logic [AW-1:0] d_addr,
  input  logic          d_write,
  input  logic [DW-1:0] d_wdata,
  input  logic [1:0]    d_size,
  input  logic          d_more,
  input  logic          burst_open,
  output logic          pend,
  output logic          sel_data,
  output logic [AW-1:0] sel_addr,
  output logic          sel_write,
  output logic [DW-1:0] sel_wdata,
  output logic [2:0]    sel_size,
  output logic          sel_more
);
  localparam logic [2:0] FETCH_SIZE = 3'($clog2(DW/8));

  logic fetch_on_bus;

  always_comb begin
    // R7: fetches served by the enabled local memory never reach the bus
    fetch_on_bus = i_req && (!imem_on || (i_addr >= LOCAL_TOP));
    // R9: data wins; an open burst blocks fetches until its next beat
    sel_data = d_req;
    pend     = d_req || (fetch_on_bus && !burst_open);
    if (d_req) begin
      sel_addr  = d_addr;
      sel_write = d_write;
      sel_wdata = d_wdata;
      sel_size  = {1'b0, d_size};
      sel_more  = d_more;
    end else begin
      sel_addr  = i_addr;
      sel_write = 1'b0;
      sel_wdata = '0;
      sel_size  = FETCH_SIZE;
      sel_more  = 1'b0;
    end
  end
endmodule

// File: rtl/bmu_ahb_master.sv
module bmu_ahb_master
  import bmu_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] LOCAL_TOP = 'h0001_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          imem_on,
  input  logic          i_req,
  input  logic [AW-1:0] i_addr,
  output logic          i_done,
  input  logic          d_req,
  input  logic [AW-1:0] d_addr,
  input  logic          d_write,
  input  logic [DW-1:0] d_wdata,
  input  logic [1:0]    d_size,
  input  logic          d_more,
  output logic          d_done,
  output logic [DW-1:0] core_rdata,
  output logic          hbusreq,
  input  logic          hgrant,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata
);
  phase_t        ph;
  htrans_t       htrans_q;
  logic          hbusreq_q, hwrite_q, burst_open, cur_data, cur_more;
  logic [AW-1:0] haddr_q, seq_addr, sel_addr;
  logic [2:0]    hsize_q, hburst_q, sel_size;
  logic [DW-1:0] hwdata_q, rdata_q, sel_wdata;
  logic          i_done_q, d_done_q;
  logic          pend, sel_data, sel_write, sel_more;
  logic          launch, use_seq, stay_open;

  bmu_req_select #(.AW(AW), .DW(DW), .LOCAL_TOP(LOCAL_TOP)) u_sel (
    .imem_on(imem_on), .i_req(i_req), .i_addr(i_addr),
    .d_req(d_req), .d_addr(d_addr), .d_write(d_write), .d_wdata(d_wdata),
    .d_size(d_size), .d_more(d_more), .burst_open(burst_open),
    .pend(pend), .sel_data(sel_data), .sel_addr(sel_addr),
    .sel_write(sel_write), .sel_wdata(sel_wdata), .sel_size(sel_size),
    .sel_more(sel_more)
  );

  bmu_addr_step #(.AW(AW)) u_step (
    .base(haddr_q), .size(hsize_q), .next(seq_addr)
  );

  assign launch    = (ph == PH_IDLE) && hready && hgrant && pend;
  assign use_seq   = sel_data && burst_open;
  assign stay_open = burst_open && hgrant;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      htrans_q   <= TR_IDLE;
      hbusreq_q  <= 1'b0;
      haddr_q    <= '0;
      hwrite_q   <= 1'b0;
      hsize_q    <= '0;
      hburst_q   <= BURST_SINGLE;
      hwdata_q   <= '0;
      rdata_q    <= '0;
      burst_open <= 1'b0;
      cur_data   <= 1'b0;
      cur_more   <= 1'b0;
      i_done_q   <= 1'b0;
      d_done_q   <= 1'b0;
    end else begin
      i_done_q <= 1'b0;
      d_done_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (launch) begin
            ph        <= PH_ADDR;
            htrans_q  <= use_seq ? TR_SEQ : TR_NONSEQ;
            haddr_q   <= use_seq ? seq_addr : sel_addr;
            hwrite_q  <= sel_write;
            hsize_q   <= sel_size;
            hburst_q  <= (use_seq || sel_more) ? BURST_INCR : BURST_SINGLE;
            hwdata_q  <= sel_wdata;
            cur_data  <= sel_data;
            cur_more  <= sel_more;
            hbusreq_q <= sel_more;
          end else begin
            hbusreq_q <= pend || burst_open;
            if (hready) begin
              burst_open <= stay_open;
              htrans_q   <= stay_open ? TR_BUSY : TR_IDLE;
            end
          end
        end
        PH_ADDR: begin
          if (hready) begin
            ph         <= PH_DATA;
            burst_open <= cur_more && hgrant;
            htrans_q   <= (cur_more && hgrant) ? TR_BUSY : TR_IDLE;
          end
        end
        PH_DATA: begin
          if (hready) begin
            ph         <= PH_IDLE;
            rdata_q    <= hrdata;
            d_done_q   <= cur_data;
            i_done_q   <= !cur_data;
            burst_open <= stay_open;
            htrans_q   <= stay_open ? TR_BUSY : TR_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign htrans     = htrans_q;
  assign hbusreq    = hbusreq_q;
  assign haddr      = haddr_q;
  assign hwrite     = hwrite_q;
  assign hsize      = hsize_q;
  assign hburst     = hburst_q;
  assign hwdata     = hwdata_q;
  assign core_rdata = rdata_q;
  assign i_done     = i_done_q;
  assign d_done     = d_done_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (htrans == 2'b00 && !hbusreq && !i_done && !d_done));

  p_launch_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && $past(htrans) != 2'b10) |-> $past(hgrant && hready));

  p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!hready) && $past(htrans[1])) |->
      ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

  p_seq_is_incr_r4: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b11) |-> (hburst == BURST_INCR));

  p_seq_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b11 && $past(htrans) != 2'b11) |-> ($past(htrans) == 2'b01));

  p_fetch_then_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(hready) && $past(htrans) == 2'b10 && !cur_data) |-> (htrans == 2'b00));

  p_done_after_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (i_done || d_done) |-> ($past(hready) && $onehot0({i_done, d_done})));

  p_idle_without_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $past(hready && !hgrant) |-> (htrans == 2'b00));
endmodule

// File: tb/bmu_ahb_master_tb.sv
module bmu_ahb_master_tb;
  localparam logic [31:0] LTOP = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        imem_on = 1'b0, i_req = 1'b0, d_req = 1'b0, d_write = 1'b0, d_more = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0, d_wdata = '0;
  logic [1:0]  d_size = 2'd2;
  logic        i_done, d_done, hbusreq, hwrite;
  logic [31:0] core_rdata, haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic        hgrant = 1'b0, hready = 1'b1;

  bmu_ahb_master #(.AW(32), .DW(32), .LOCAL_TOP(LTOP)) u_dut (
    .clk(clk), .rst(rst), .imem_on(imem_on), .i_req(i_req), .i_addr(i_addr),
    .i_done(i_done), .d_req(d_req), .d_addr(d_addr), .d_write(d_write),
    .d_wdata(d_wdata), .d_size(d_size), .d_more(d_more), .d_done(d_done),
    .core_rdata(core_rdata), .hbusreq(hbusreq), .hgrant(hgrant), .htrans(htrans),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .hready(hready), .hrdata(hrdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rexp(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] wexp(input logic [31:0] a);
    return a ^ 32'hA5A5_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // arbiter and slave models
  logic       rnd_revoke = 1'b0, force_revoke = 1'b0;
  int         gcnt = 0, wcnt = 0;
  logic       dph = 1'b0, dwr = 1'b0;
  logic [31:0] daddr = '0;
  assign hrdata = dph ? rexp(daddr) : 32'h0;

  always @(posedge clk) begin
    if (rst) begin
      hgrant <= 1'b0; gcnt <= 0;
    end else if (force_revoke) begin
      hgrant <= 1'b0; gcnt <= 3;
    end else if (hgrant && rnd_revoke && ($urandom % 12 == 0)) begin
      hgrant <= 1'b0; gcnt <= 1 + int'($urandom % 3);
    end else if (!hbusreq) begin
      hgrant <= 1'b0; gcnt <= int'($urandom % 3);
    end else if (gcnt != 0) begin
      gcnt <= gcnt - 1;
    end else begin
      hgrant <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      hready <= 1'b1; dph <= 1'b0; wcnt <= 0;
    end else if (hready) begin
      dph <= htrans[1]; daddr <= haddr; dwr <= hwrite;
      if (htrans[1]) begin
        int w;
        w = int'($urandom % 3);
        hready <= (w == 0); wcnt <= w;
      end else if ($urandom % 6 == 0) begin
        hready <= 1'b0; wcnt <= 1;
      end
    end else begin
      wcnt <= wcnt - 1;
      hready <= (wcnt == 1);
    end
  end

  // bus monitor, sampled on the falling edge
  logic        mon_on = 1'b0, idle_seen = 1'b1;
  logic        p_hgrant = 0, p_hready = 1, p_dph = 0, p_dwr = 0, p_hwrite = 0;
  logic [1:0]  p_htrans = 0;
  logic [31:0] p_haddr = 0, p_hwdata = 0, p_daddr = 0;
  logic [2:0]  p_hsize = 0, p_hburst = 0;
  logic [1:0]  la_trans = 0;
  logic [31:0] la_addr = 0;
  logic [2:0]  la_size = 0, la_burst = 0;
  logic        la_write = 0, la_gap = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (htrans == 2'b10 && p_htrans != 2'b10)
        chk(p_hgrant && p_hready, "R2 launch without grant", {30'd0, p_hgrant, p_hready}, 32'd3);
      if (!p_hready && p_htrans[1])
        chk(htrans == p_htrans && haddr == p_haddr && hwrite == p_hwrite, "R3 hold", haddr, p_haddr);
      if (p_hready && !p_hgrant)
        chk(htrans == 2'b00, "R10 idle after grant loss", {30'd0, htrans}, 32'd0);
      if (p_hready && p_dph && p_dwr)
        chk(p_hwdata == wexp(p_daddr), "R8 write data", p_hwdata, wexp(p_daddr));
      if (p_hready && p_htrans[1]) begin
        if (p_htrans == 2'b11)
          chk(!idle_seen && p_hburst == 3'b001 && p_haddr == la_addr + (32'd1 << la_size),
              "R4 seq beat", p_haddr, la_addr + (32'd1 << la_size));
        la_trans = p_htrans; la_addr = p_haddr; la_size = p_hsize;
        la_burst = p_hburst; la_write = p_hwrite; la_gap = idle_seen;
        idle_seen = 1'b0;
      end
      if (htrans == 2'b00) idle_seen = 1'b1;
    end
    p_hgrant = hgrant; p_hready = hready; p_htrans = htrans; p_haddr = haddr;
    p_hwrite = hwrite; p_hsize = hsize; p_hburst = hburst; p_hwdata = hwdata;
    p_dph = dph; p_dwr = dwr; p_daddr = daddr;
  end

  // core-side drivers, called on a falling edge
  task automatic data_xfer(input logic [31:0] a, input bit w, input logic [1:0] sz, input bit mr);
    d_addr = a; d_write = w; d_wdata = wexp(a); d_size = sz; d_more = mr; d_req = 1'b1;
    do @(negedge clk); while (!d_done);
    if (!w) chk(core_rdata == rexp(a), "R8 data read", core_rdata, rexp(a));
    d_req = 1'b0;
  endtask

  task automatic fetch_wait(input logic [31:0] a);
    do @(negedge clk); while (!i_done);
    chk(core_rdata == rexp(a), "R8 fetch read", core_rdata, rexp(a));
    i_req = 1'b0;
  endtask

  task automatic fetch_xfer(input logic [31:0] a);
    i_addr = a; i_req = 1'b1;
    fetch_wait(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int td, ti;
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b00 && !hbusreq && !i_done && !d_done, "R1 reset state",
        {28'd0, htrans, hbusreq, i_done}, 32'd0);
    mon_on = 1'b1;

    // R5: lone data read
    data_xfer(32'h2000_0040, 1'b0, 2'd2, 1'b0);
    chk(la_trans == 2'b10 && la_burst == 3'b000 && la_addr == 32'h2000_0040,
        "R5 single nonseq", la_addr, 32'h2000_0040);

    // R4/R5: three-beat halfword burst
    data_xfer(32'h2000_0100, 1'b0, 2'd1, 1'b1);
    chk(la_trans == 2'b10 && la_burst == 3'b001, "R5 burst head INCR", {29'd0, la_burst}, 32'd1);
    data_xfer(32'h2000_0102, 1'b1, 2'd1, 1'b1);
    data_xfer(32'h2000_0104, 1'b0, 2'd1, 1'b0);
    chk(la_trans == 2'b11 && la_addr == 32'h2000_0104 && la_burst == 3'b001,
        "R4 last beat SEQ", la_addr, 32'h2000_0104);
    repeat (4) @(negedge clk);
    chk(!hbusreq, "R11 request dropped", {31'd0, hbusreq}, 32'd0);

    // R6: fetches
    imem_on = 1'b0;
    fetch_xfer(32'h0000_0200);
    fetch_xfer(32'h0000_0204);
    chk(la_trans == 2'b10 && la_burst == 3'b000 && la_size == 3'b010 && !la_write && la_gap,
        "R6 fetch shape", {la_trans, la_burst, la_size, la_write, la_gap}, {2'b10, 3'b000, 3'b010, 2'b01});
    chk(htrans == 2'b00, "R6 idle after fetch", {30'd0, htrans}, 32'd0);

    // R7: local fetch ignored
    imem_on = 1'b1; i_addr = 32'h0000_0100; i_req = 1'b1;
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (hbusreq || htrans != 2'b00 || i_done) seen = 1'b1;
    end
    chk(!seen, "R7 local fetch ignored", {31'd0, seen}, 32'd0);
    i_req = 1'b0;
    @(negedge clk);
    chk(!hbusreq, "R11 idle no request", {31'd0, hbusreq}, 32'd0);

    // R9: simultaneous requests, data first
    imem_on = 1'b0; i_addr = 32'h0000_0300; i_req = 1'b1;
    td = 0; ti = 0;
    fork
      begin data_xfer(32'h2000_0200, 1'b0, 2'd2, 1'b0); td = cyc; end
      begin fetch_wait(32'h0000_0300); ti = cyc; end
    join
    chk(td < ti, "R9 data before fetch", td, ti);

    // R9: fetch waits behind open burst
    data_xfer(32'h2000_0300, 1'b0, 2'd2, 1'b1);
    i_addr = 32'h0000_0400; i_req = 1'b1;
    seen = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (i_done || htrans == 2'b10) seen = 1'b1;
    end
    chk(!seen && htrans == 2'b01, "R9 fetch held in burst", {30'd0, htrans}, 32'd1);
    fork
      begin data_xfer(32'h2000_0304, 1'b0, 2'd2, 1'b0); td = cyc; end
      begin fetch_wait(32'h0000_0400); ti = cyc; end
    join
    chk(td < ti && la_trans == 2'b10, "R9 beat then fetch", td, ti);

    // R10: grant removed mid-burst
    fork
      data_xfer(32'h2000_0400, 1'b0, 2'd2, 1'b1);
      begin
        do @(negedge clk); while (htrans != 2'b01);
        force_revoke = 1'b1;
        @(negedge clk);
        force_revoke = 1'b0;
      end
    join
    data_xfer(32'h2000_0480, 1'b0, 2'd2, 1'b0);
    chk(la_trans == 2'b10 && la_addr == 32'h2000_0480, "R10 restart nonseq", la_addr, 32'h2000_0480);

    // random traffic
    rnd_revoke = 1'b1;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 3 == 0) begin
        imem_on = 1'($urandom % 2);
        fetch_xfer(imem_on ? LTOP + 32'(($urandom % 1024) * 4) : 32'(($urandom % 4096) * 4));
      end else begin
        int len;
        logic [1:0] sz;
        logic [31:0] base;
        bit w;
        len = 1 + int'($urandom % 4);
        sz = 2'($urandom % 3);
        base = 32'h2000_0000 + 32'(($urandom % 256) * 4);
        w = 1'($urandom % 2);
        for (int b = 0; b < len; b++)
          data_xfer(base + 32'(b << sz), w, sz, b != len - 1);
      end
      repeat ($urandom % 4) @(negedge clk);
    end
    rnd_revoke = 1'b0;
    repeat (8) @(negedge clk);
    chk(!hbusreq && htrans == 2'b00, "R11 quiet at end", {29'd0, hbusreq, htrans}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule